// File: doc/BRIEF.md
# Run-Length Alarm with Transition-Density Release

This block watches a recovered serial bit stream that arrives one bit per clock cycle in which the bit enable is high. It counts how many accepted bits in a row carry the same value. When that run grows past a programmable limit (256 by default), it raises an alarm: the stream has gone quiet, either stuck at zero or stuck at one, and the recovered data should be treated as lost.

The alarm has deliberately lopsided hysteresis. Once it is raised, run length no longer matters. The alarm is released only when transition activity comes back densely enough. The block slices the accepted bits into fixed windows of 128 bits, starting at the first accepted bit after the alarm rises. It releases the alarm as soon as 16 transitions have been seen inside one window. A window that ends short of that count is thrown away, and counting starts again in a fresh window. Bits offered while the enable is low are ignored completely.

A second output combines the alarm with an external frequency-lock status, so that downstream logic receives one data-loss indication.

Top module: `run_length_alarm`

## Requirements
- R1: While reset is asserted, and after it is released, `alarm_o` is 0. The first accepted bit after reset starts a run of length 1.
- R2: `alarm_o` rises at the clock edge that accepts the 257th consecutive identical bit (RUN_LIMIT+1), for a run of zeros and for a run of ones alike. After 256 identical bits it is still 0.
- R3: An accepted bit that differs from the previous accepted bit (a 0-to-1 or a 1-to-0 transition) restarts the run at length 1.
- R4: Cycles with `bit_en` at 0 are ignored. Their `bit_in` values neither count toward a run nor restart it, and they are not used as the previous bit for transition detection.
- R5: While `alarm_o` is 1, accepted bits without a transition never clear it, however long the run becomes.
- R6: While `alarm_o` is 1, accepted bits are grouped into windows of 128 bits. The first window begins with the first accepted bit after the edge that raised the alarm. `alarm_o` falls at the edge that accepts the 16th transition inside one window, including when that transition is the 128th bit of the window.
- R7: A window that ends with fewer than 16 transitions is discarded. Its transitions do not count toward the next window, which starts at the following accepted bit.
- R8: `alarm_o` changes only at clock edges where `bit_en` is 1.
- R9: `data_loss_o` is 1 whenever `alarm_o` is 1 or `lock_ok_i` is 0, and 0 otherwise. It follows `lock_ok_i` without a clock delay.
- R10: The internal run length saturates at its maximum value (511 by default) and does not wrap. A run of 1000 identical bits keeps `alarm_o` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | Bit enable: `bit_in` is accepted on this cycle |
| bit_in | input | 1 | Recovered data bit |
| lock_ok_i | input | 1 | Frequency-lock status from the loop, 1 = locked |
| alarm_o | output | 1 | Run-length alarm |
| data_loss_o | output | 1 | Alarm combined with loss of frequency lock |

## Verification
The assertions assume that `bit_en` and `bit_in` are synchronous to `clk` and stable around its rising edge. They also assume that reset is held across at least one edge, so that the tracker's "seen a bit" state starts clean. The stimulus respects this by changing every input on the falling edge only. During its idle stretches it toggles `bit_in` with `bit_en` low, which tests that the sampling ignores such bits. The window checks place the 16th transition exactly on the last bit of a window, and one bit past it, because an off-by-one in the window boundary would show up only there.

// File: rtl/ralm_pkg.sv
package ralm_pkg;

   // Width that can hold values 0..max_val (at least 1 bit).
   function automatic int unsigned width_for(input int unsigned max_val);
      int unsigned w;
      w = 1;
      while ((1 << w) <= max_val) w++;
      return w;
   endfunction

   // One accepted-bit event as seen by the counters.
   typedef struct packed {
      logic take;    // bit accepted this cycle
      logic first;   // first accepted bit since reset
      logic flip;    // differs from previous accepted bit
   } bit_evt_t;

endpackage

// File: rtl/ralm_bit_tracker.sv
module ralm_bit_tracker
   import ralm_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     en,
   input  logic     din,
   output bit_evt_t evt
);

   logic last_q;
   logic seen_q;

   always_comb begin
      evt.take  = en;
      evt.first = en & ~seen_q;
      evt.flip  = en & seen_q & (din ^ last_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_q <= 1'b0;
         seen_q <= 1'b0;
      end else if (en) begin
         last_q <= din;
         seen_q <= 1'b1;
      end
   end

endmodule

// File: rtl/ralm_run_counter.sv
module ralm_run_counter
   import ralm_pkg::*;
#(
   parameter int unsigned RUN_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  bit_evt_t         evt,
   output logic [RUN_W-1:0] run_q,
   output logic [RUN_W-1:0] run_next
);

   localparam logic [RUN_W-1:0] RUN_MAX = {RUN_W{1'b1}};
   localparam logic [RUN_W-1:0] RUN_ONE = RUN_W'(1);

   always_comb begin
      if (!evt.take)
         run_next = run_q;
      else if (evt.first || evt.flip)
         run_next = RUN_ONE;
      else if (run_q == RUN_MAX)
         run_next = RUN_MAX;
      else
         run_next = run_q + RUN_ONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         run_q <= '0;
      else
         run_q <= run_next;
   end

endmodule

// File: rtl/ralm_density_window.sv
module ralm_density_window
   import ralm_pkg::*;
#(
   parameter int unsigned WIN_BITS  = 128,
   parameter int unsigned CLR_EDGES = 16
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     active,
   input  bit_evt_t evt,
   output logic     release_hit
);

   localparam int unsigned WIN_W = width_for(WIN_BITS - 1);
   localparam int unsigned TR_W  = width_for(CLR_EDGES);
   localparam bit          WIN_POW2 = ((WIN_BITS & (WIN_BITS - 1)) == 0);

   logic [WIN_W-1:0] pos_q;
   logic [TR_W-1:0]  hits_q;
   logic [TR_W-1:0]  hits_sum;
   logic             win_end;

   generate
      if (WIN_POW2) begin : g_end_pow2
         // Power-of-two window: last bit when every position bit is set.
         assign win_end = &pos_q;
      end else begin : g_end_cmp
         assign win_end = (pos_q == WIN_W'(WIN_BITS - 1));
      end
   endgenerate

   assign hits_sum    = hits_q + TR_W'(evt.flip);
   assign release_hit = active & evt.take & (hits_sum >= TR_W'(CLR_EDGES));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q  <= '0;
         hits_q <= '0;
      end else if (!active || release_hit) begin
         pos_q  <= '0;
         hits_q <= '0;
      end else if (evt.take) begin
         if (win_end) begin
            pos_q  <= '0;
            hits_q <= '0;
         end else begin
            pos_q  <= pos_q + WIN_W'(1);
            hits_q <= hits_sum;
         end
      end
   end

endmodule

// File: rtl/run_length_alarm.sv
module run_length_alarm
   import ralm_pkg::*;
#(
   parameter int unsigned RUN_LIMIT = 256,
   parameter int unsigned WIN_BITS  = 128,
   parameter int unsigned CLR_EDGES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_en,
   input  logic bit_in,
   input  logic lock_ok_i,
   output logic alarm_o,
   output logic data_loss_o
);

   localparam int unsigned      RUN_W   = width_for(RUN_LIMIT + 1);
   localparam logic [RUN_W-1:0] LIMIT_V = RUN_W'(RUN_LIMIT);

   generate
      if (RUN_LIMIT < 1) begin : g_bad_limit
         $error("run_length_alarm: RUN_LIMIT must be at least 1");
      end
      if (WIN_BITS < 2) begin : g_bad_win
         $error("run_length_alarm: WIN_BITS must be at least 2");
      end
      if (CLR_EDGES < 1 || CLR_EDGES > WIN_BITS) begin : g_bad_clr
         $error("run_length_alarm: CLR_EDGES must lie in 1..WIN_BITS");
      end
   endgenerate

   bit_evt_t         evt;
   logic             edge_w;
   logic [RUN_W-1:0] run_q;
   logic [RUN_W-1:0] run_next;
   logic             release_hit;
   logic             alarm_q;

   ralm_bit_tracker u_track (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (bit_en),
      .din   (bit_in),
      .evt   (evt)
   );

   assign edge_w = evt.flip;

   ralm_run_counter #(
      .RUN_W (RUN_W)
   ) u_run (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (evt),
      .run_q    (run_q),
      .run_next (run_next)
   );

   ralm_density_window #(
      .WIN_BITS  (WIN_BITS),
      .CLR_EDGES (CLR_EDGES)
   ) u_win (
      .clk         (clk),
      .rst_n       (rst_n),
      .active      (alarm_q),
      .evt         (evt),
      .release_hit (release_hit)
   );

   // Asymmetric hysteresis: set on run length, clear only on density.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         alarm_q <= 1'b0;
      else if (bit_en) begin
         if (alarm_q)
            alarm_q <= ~release_hit;
         else
            alarm_q <= (run_next > LIMIT_V);
      end
   end

   assign alarm_o     = alarm_q;
   assign data_loss_o = alarm_q | ~lock_ok_i;

endmodule

// File: rtl/ralm_checker.sv
module ralm_checker #(
   parameter int unsigned RUN_LIMIT = 256,
   parameter int unsigned RUN_W     = 9
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bit_en,
   input logic             alarm_o,
   input logic             edge_w,
   input logic [RUN_W-1:0] run_q
);

   localparam logic [RUN_W-1:0] RUN_MAX = {RUN_W{1'b1}};

   // R1: reset forces the alarm low
   p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |=> !alarm_o);

   // R2: a rising alarm is always backed by an over-limit run
   p_rise_needs_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alarm_o) |-> (run_q > RUN_W'(RUN_LIMIT)));

   // R3: a transition restarts the run at one
   p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && edge_w) |=> (run_q == RUN_W'(1)));

   // R5: without a transition the alarm cannot fall
   p_hold_alarm_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (alarm_o && !edge_w) |=> alarm_o);

   // R8: the alarm only moves on accepted bits
   p_idle_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> $stable(alarm_o));

   // R10: a saturated run stays saturated until a transition
   p_run_saturates_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && !edge_w && run_q == RUN_MAX) |=> (run_q == RUN_MAX));

endmodule

bind run_length_alarm ralm_checker #(
   .RUN_LIMIT (RUN_LIMIT),
   .RUN_W     (RUN_W)
) u_ralm_checker (
   .clk     (clk),
   .rst_n   (rst_n),
   .bit_en  (bit_en),
   .alarm_o (alarm_o),
   .edge_w  (edge_w),
   .run_q   (run_q)
);

// File: tb/run_length_alarm_bench.sv
module run_length_alarm_bench;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bit_en = 1'b0;
   logic bit_in = 1'b0;
   logic lock_ok_i = 1'b1;
   logic alarm_o;
   logic data_loss_o;

   int checks = 0;
   int fails  = 0;

   run_length_alarm u_run_length_alarm (
      .clk         (clk),
      .rst_n       (rst_n),
      .bit_en      (bit_en),
      .bit_in      (bit_in),
      .lock_ok_i   (lock_ok_i),
      .alarm_o     (alarm_o),
      .data_loss_o (data_loss_o)
   );

   always #5 clk = ~clk;

   // Reference state built from the requirements
   int m_run = 0;
   bit m_seen = 0;
   bit m_last = 0;
   bit m_alarm = 0;
   int m_pos = 0;
   int m_hits = 0;

   bit    exp_q[$];
   string tag_q[$];
   string cur_tag = "R1";

   task automatic check(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model(input bit en, input bit b);
      bit e;
      if (en) begin
         e = m_seen && (b != m_last);
         if (e || !m_seen) m_run = 1;
         else if (m_run < 511) m_run++;
         if (m_alarm) begin
            m_pos++;
            m_hits += int'(e);
            if (m_hits >= 16) begin
               m_alarm = 0; m_pos = 0; m_hits = 0;
            end else if (m_pos == 128) begin
               m_pos = 0; m_hits = 0;
            end
         end else if (m_run > 256) begin
            m_alarm = 1;
         end
         m_last = b;
         m_seen = 1;
      end
   endtask

   // Driver: one cycle of stimulus, expected result pushed to the scoreboard
   task automatic step(input bit en, input bit b);
      @(negedge clk);
      bit_en = en;
      bit_in = b;
      model(en, b);
      exp_q.push_back(m_alarm);
      tag_q.push_back(cur_tag);
   endtask

   task automatic send_n(input bit b, input int n);
      for (int i = 0; i < n; i++) step(1'b1, b);
   endtask

   task automatic toggles(input int n);
      for (int i = 0; i < n; i++) step(1'b1, ~m_last);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b0, i[0]);
   endtask

   task automatic settle();
      @(posedge clk);
      #2;
   endtask

   task automatic arm();
      send_n(~m_last, 257);
   endtask

   // Monitor: compare after every active edge
   always @(posedge clk) begin
      #2;
      if (exp_q.size() > 0) begin
         automatic bit    e = exp_q.pop_front();
         automatic string t = tag_q.pop_front();
         check(t, alarm_o, e);
         check({t, " R9 loss"}, data_loss_o, e | ~lock_ok_i);
      end
   end

   initial begin
      #(200000 * 10);
      fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1 alarm in reset", alarm_o, 1'b0);
      lock_ok_i = 1'b0;
      #1 check("R9 loss without lock", data_loss_o, 1'b1);
      lock_ok_i = 1'b1;
      #1 check("R9 loss with lock", data_loss_o, 1'b0);
      rst_n = 1'b1;
      settle();
      check("R1 alarm after reset", alarm_o, 1'b0);

      // R2: ones from reset, first bit is run of one
      cur_tag = "R2 ones";
      send_n(1'b1, 256);
      settle();
      check("R2 256 ones", alarm_o, 1'b0);
      send_n(1'b1, 1);
      settle();
      check("R2 257 ones", alarm_o, 1'b1);

      // R6: 16 quick transitions clear
      cur_tag = "R6 quick";
      toggles(15);
      settle();
      check("R6 15 transitions", alarm_o, 1'b1);
      toggles(1);
      settle();
      check("R6 16th transition", alarm_o, 1'b0);

      // R3: restart, and zeros polarity for R2
      cur_tag = "R3 restart";
      send_n(1'b1, 200);
      send_n(1'b0, 256);
      settle();
      check("R3 256 zeros after restart", alarm_o, 1'b0);
      cur_tag = "R2 zeros";
      send_n(1'b0, 1);
      settle();
      check("R2 257 zeros", alarm_o, 1'b1);
      cur_tag = "R3 clear";
      toggles(16);

      // R4: disabled bits do not break or extend a run
      cur_tag = "R4 idle";
      send_n(1'b1, 250);
      idle(20);
      send_n(1'b1, 6);
      settle();
      check("R4 256 accepted ones with idle gap", alarm_o, 1'b0);
      send_n(1'b1, 1);
      settle();
      check("R4 257th accepted one", alarm_o, 1'b1);

      // R5 / R8 / R10: long run and idle while alarmed
      cur_tag = "R5 R10 long run";
      send_n(1'b1, 1000);
      settle();
      check("R10 1000 more ones", alarm_o, 1'b1);
      cur_tag = "R8 idle";
      idle(30);
      settle();
      check("R8 idle while alarmed", alarm_o, 1'b1);
      cur_tag = "R10 clear";
      toggles(16);
      settle();
      check("R10 clear after saturation", alarm_o, 1'b0);

      // R7: short window is discarded
      cur_tag = "R7 discard";
      arm();
      toggles(15);
      send_n(m_last, 113);
      toggles(15);
      settle();
      check("R7 15 in second window", alarm_o, 1'b1);
      toggles(1);
      settle();
      check("R7 16 in second window", alarm_o, 1'b0);

      // R6: 16th transition on the last bit of the window
      cur_tag = "R6 boundary";
      arm();
      for (int g = 0; g < 16; g++) begin
         send_n(m_last, 7);
         toggles(1);
      end
      settle();
      check("R6 16th on bit 128", alarm_o, 1'b0);

      // R7: 16th transition one bit late
      cur_tag = "R7 late";
      arm();
      send_n(m_last, 1);
      for (int g = 0; g < 16; g++) begin
         send_n(m_last, 7);
         toggles(1);
      end
      settle();
      check("R7 16th on bit 129", alarm_o, 1'b1);
      toggles(15);
      settle();
      check("R7 refill second window", alarm_o, 1'b0);

      // R9: lock loss while clear
      cur_tag = "R9 lock";
      lock_ok_i = 1'b0;
      send_n(1'b1, 4);
      lock_ok_i = 1'b1;
      send_n(1'b1, 4);

      wait (exp_q.size() == 0);
      settle();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule